// File: doc/BRIEF.md
# Analog-Output Board Host Register Decoder

This block sits between a 16-bit host register bus and the rest of a multi-channel analog-output board. It holds three configuration words and three latched event flags. It presents a read-only status word, and it turns bus accesses into single-cycle strobes for the sample queue and for the per-channel converters. The converters, the queue storage, the counter/timer and the DMA engine sit outside the block. They are seen only through the flag inputs and the strobe outputs.

The bus addresses 16-bit words, so `bus_addr` is the word index: byte offset = 2 × index. One bit of configuration word 1 is the bank select. While it is set, the three lowest word offsets stop acting as configuration writes and become write-to-clear strobes for the event flags. The sample-queue port also stops accepting data and becomes output channel 0's data register. Some offsets mean one thing on write and another on read. A write to word 5 loads configuration word 1, while a read of word 5 returns status. A write to word 6 pushes a sample, while a read of word 6 clears the queue.

Top module: `ao_hostreg`

## Requirements
- R1: After reset, `cfg1_q`, `cfg2_q` and `cfg3_q` are 0, all three event flags are clear and every strobe output (`fifo_wr`, `fifo_clr`, `dac_wr`) is low.
- R2: A write to word 5 (byte offset 0x0a) loads configuration word 1 as `bus_wdata & 16'hF9FF`, in either bank. Bit 7 of configuration word 1 is the bank select, with 1 meaning bank 2. Bits 10:9 always read 0.
- R3: While `bus_rd` is high and `bus_addr` is 5, `bus_rdata` is `{9'b0, fifo_half, fifo_empty, fifo_full, flag_int2, flag_int1, flag_tc, prom_dout}`, with `prom_dout` in bit 0. In the same cycle, with no register between, it reflects the flags as they stand.
- R4: With bank 2 deselected, a write to word 1 loads `cfg2_q` with all 16 data bits. A write to word 2 loads `cfg3_q` as `bus_wdata & 16'h004F`.
- R5: With bank 2 selected, a write to word 0 clears the terminal-count flag, a write to word 1 clears interrupt flag 1, and a write to word 2 clears interrupt flag 2. `cfg2_q` and `cfg3_q` keep their values.
- R6: A one-cycle pulse on `ev_tc`, `ev_int1` or `ev_int2` sets its flag at the next clock edge, and the flag then stays set until it is cleared. If a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R7: With bank 2 deselected, a write to word 6 (byte offset 0x0c) raises `fifo_wr` for exactly the following cycle, with `fifo_wdata` equal to the written word.
- R8: A read of word 6, in either bank, raises `fifo_clr` for exactly the following cycle.
- R9: A write to word 6+n, for 1 ≤ n < NUM_CH and in either bank, raises `dac_wr` for the following cycle. In that cycle `dac_ch` = n and `dac_data` = `bus_wdata[11:0]`.
- R10: With bank 2 selected, a write to word 6 drives `dac_wr` with `dac_ch` = 0 and does not raise `fifo_wr`. `fifo_wr` and `dac_wr` are never high together.
- R11: Writes to word 3 or 4, writes to word 0 with bank 2 deselected, and reads of any word other than 5 leave every register unchanged and raise no strobe. Those reads return 0 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 4 | Word index (byte offset / 2) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| ev_tc | input | 1 | DMA terminal-count event pulse |
| ev_int1 | input | 1 | Interrupt source 1 event pulse |
| ev_int2 | input | 1 | Interrupt source 2 event pulse |
| fifo_half | input | 1 | Sample queue half-full level |
| fifo_empty | input | 1 | Sample queue empty level |
| fifo_full | input | 1 | Sample queue full level |
| prom_dout | input | 1 | Serial PROM data-out line |
| cfg1_q | output | 16 | Configuration word 1 |
| cfg2_q | output | 16 | Configuration word 2 (calibration serial lines) |
| cfg3_q | output | 16 | Configuration word 3 |
| fifo_wr | output | 1 | Sample push strobe |
| fifo_wdata | output | 16 | Sample push data |
| fifo_clr | output | 1 | Sample queue clear strobe |
| dac_wr | output | 1 | Channel data strobe |
| dac_ch | output | 4 | Channel index for `dac_wr` |
| dac_data | output | 12 | Channel data for `dac_wr` |

## Verification
The stimulus writes the same offsets 0, 1, 2 and 6 once with the bank bit clear and once with it set. This separates the configuration path from the flag-clear path and the queue path from the channel-0 path. Flag pulses are applied alone, then together with the matching clear, so that the set-over-clear priority is distinguished from a plain clear. All-ones and mixed patterns written to configuration words 1 and 3 reveal any bit that should have been dropped. Writes to each channel register with distinct data catch an off-by-one in the channel index.

// File: rtl/ao_hostreg_pkg.sv
package ao_hostreg_pkg;

   // word indices (byte offset / 2)
   localparam int WI_LOW0 = 0;   // bank 2: clear terminal-count flag
   localparam int WI_LOW1 = 1;   // bank 0: config 2 / bank 2: clear int 1
   localparam int WI_LOW2 = 2;   // bank 0: config 3 / bank 2: clear int 2
   localparam int WI_CFG1 = 5;   // write config 1, read status
   localparam int WI_PORT = 6;   // queue port / channel 0, channel n at +n

   localparam int NUM_FLAGS = 3;
   localparam int FLG_TC    = 0;
   localparam int FLG_INT1  = 1;
   localparam int FLG_INT2  = 2;

   localparam int BANK_BIT  = 7;

   localparam logic [15:0] CFG1_KEEP = 16'hF9FF;
   localparam logic [15:0] CFG2_KEEP = 16'hFFFF;
   localparam logic [15:0] CFG3_KEEP = 16'h004F;

   typedef struct packed {
      logic                 cfg1_we;
      logic                 cfg2_we;
      logic                 cfg3_we;
      logic [NUM_FLAGS-1:0] clr;
      logic                 fifo_we;
      logic                 fifo_clr;
      logic                 dac_we;
   } dec_t;

endpackage

// File: rtl/ao_hostreg_decode.sv
module ao_hostreg_decode
   import ao_hostreg_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NUM_CH = 10,
   parameter int CH_W   = 4
) (
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bank,
   output dec_t              dec,
   output logic [CH_W-1:0]   ch
);

   localparam int LAST_IDX = WI_PORT + NUM_CH - 1;

   logic [NUM_FLAGS-1:0] clr_hit;

   // bank 2 clear map: low word k clears flag k
   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_clr
      assign clr_hit[f] = bus_wr && bank && (int'(bus_addr) == f);
   end

   always_comb begin
      int idx;
      int rel;
      idx = int'(bus_addr);
      rel = idx - WI_PORT;
      dec = '0;
      ch  = '0;
      dec.clr = clr_hit;
      if (bus_wr) begin
         dec.cfg1_we = (idx == WI_CFG1);
         dec.cfg2_we = (idx == WI_LOW1) && !bank;
         dec.cfg3_we = (idx == WI_LOW2) && !bank;
         if (idx >= WI_PORT && idx <= LAST_IDX) begin
            if (rel == 0 && !bank) begin
               dec.fifo_we = 1'b1;
            end else begin
               dec.dac_we = 1'b1;
               ch         = CH_W'(rel);
            end
         end
      end
      if (bus_rd && idx == WI_PORT) begin
         dec.fifo_clr = 1'b1;
      end
   end

endmodule

// File: rtl/ao_hostreg_cfgreg.sv
module ao_hostreg_cfgreg #(
   parameter int           W    = 16,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= d & KEEP;
      end
   end

endmodule

// File: rtl/ao_hostreg_flags.sv
module ao_hostreg_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[i] <= 1'b0;
         end else if (set[i]) begin
            q[i] <= 1'b1;
         end else if (clr[i]) begin
            q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ao_hostreg_strobe.sv
module ao_hostreg_strobe #(
   parameter int DATA_W = 16,
   parameter int DAC_W  = 12,
   parameter int CH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_we,
   input  logic              fifo_clr_in,
   input  logic              dac_we,
   input  logic [CH_W-1:0]   ch_in,
   input  logic [DATA_W-1:0] wdata,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic              fifo_clr,
   output logic              dac_wr,
   output logic [CH_W-1:0]   dac_ch,
   output logic [DAC_W-1:0]  dac_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_wr  <= 1'b0;
         fifo_clr <= 1'b0;
         dac_wr   <= 1'b0;
      end else begin
         fifo_wr  <= fifo_we;
         fifo_clr <= fifo_clr_in;
         dac_wr   <= dac_we;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_wdata <= '0;
      end else if (fifo_we) begin
         fifo_wdata <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_ch   <= '0;
         dac_data <= '0;
      end else if (dac_we) begin
         dac_ch   <= ch_in;
         dac_data <= wdata[DAC_W-1:0];
      end
   end

endmodule

// File: rtl/ao_hostreg.sv
module ao_hostreg
   import ao_hostreg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter int NUM_CH = 10,
   parameter int DAC_W  = 12,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_tc,
   input  logic              ev_int1,
   input  logic              ev_int2,
   input  logic              fifo_half,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic              prom_dout,
   output logic [DATA_W-1:0] cfg1_q,
   output logic [DATA_W-1:0] cfg2_q,
   output logic [DATA_W-1:0] cfg3_q,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic              fifo_clr,
   output logic              dac_wr,
   output logic [CH_W-1:0]   dac_ch,
   output logic [DAC_W-1:0]  dac_data
);

   // elaboration-time parameter checks
   if (DATA_W != 16) begin : g_bad_data_w
      $error("ao_hostreg: DATA_W must be 16");
   end
   if (NUM_CH < 1 || WI_PORT + NUM_CH > (1 << ADDR_W)) begin : g_bad_num_ch
      $error("ao_hostreg: NUM_CH does not fit the address space");
   end
   if (DAC_W < 1 || DAC_W > DATA_W) begin : g_bad_dac_w
      $error("ao_hostreg: DAC_W out of range");
   end
   if ((1 << CH_W) < NUM_CH) begin : g_bad_ch_w
      $error("ao_hostreg: CH_W too narrow");
   end

   dec_t                 dec;
   logic [CH_W-1:0]      dec_ch;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [DATA_W-1:0]    status;

   ao_hostreg_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W)
   ) u_decode (
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bank     (cfg1_q[BANK_BIT]),
      .dec      (dec),
      .ch       (dec_ch)
   );

   ao_hostreg_cfgreg #(.W(DATA_W), .KEEP(CFG1_KEEP)) u_cfg1 (
      .clk (clk), .rst_n (rst_n), .we (dec.cfg1_we), .d (bus_wdata), .q (cfg1_q)
   );
   ao_hostreg_cfgreg #(.W(DATA_W), .KEEP(CFG2_KEEP)) u_cfg2 (
      .clk (clk), .rst_n (rst_n), .we (dec.cfg2_we), .d (bus_wdata), .q (cfg2_q)
   );
   ao_hostreg_cfgreg #(.W(DATA_W), .KEEP(CFG3_KEEP)) u_cfg3 (
      .clk (clk), .rst_n (rst_n), .we (dec.cfg3_we), .d (bus_wdata), .q (cfg3_q)
   );

   assign flag_set[FLG_TC]   = ev_tc;
   assign flag_set[FLG_INT1] = ev_int1;
   assign flag_set[FLG_INT2] = ev_int2;

   ao_hostreg_flags #(.N(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (dec.clr),
      .q     (flag_q)
   );

   ao_hostreg_strobe #(
      .DATA_W (DATA_W),
      .DAC_W  (DAC_W),
      .CH_W   (CH_W)
   ) u_strobe (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_we     (dec.fifo_we),
      .fifo_clr_in (dec.fifo_clr),
      .dac_we      (dec.dac_we),
      .ch_in       (dec_ch),
      .wdata       (bus_wdata),
      .fifo_wr     (fifo_wr),
      .fifo_wdata  (fifo_wdata),
      .fifo_clr    (fifo_clr),
      .dac_wr      (dac_wr),
      .dac_ch      (dac_ch),
      .dac_data    (dac_data)
   );

   always_comb begin
      status      = '0;
      status[6:0] = {fifo_half, fifo_empty, fifo_full,
                     flag_q[FLG_INT2], flag_q[FLG_INT1], flag_q[FLG_TC], prom_dout};
   end

   assign bus_rdata = (bus_rd && int'(bus_addr) == WI_CFG1) ? status : '0;

endmodule

// File: rtl/ao_hostreg_chk.sv
module ao_hostreg_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter int NUM_CH = 10,
   parameter int CH_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] cfg1_q,
   input logic [DATA_W-1:0] cfg3_q,
   input logic [2:0]        flag_q,
   input logic              ev_int1,
   input logic              fifo_wr,
   input logic [DATA_W-1:0] fifo_wdata,
   input logic              fifo_clr,
   input logic              dac_wr,
   input logic [CH_W-1:0]   dac_ch
);

   a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg1_q == '0 && cfg3_q == '0 && flag_q == '0));

   a_r5_bank_keeps_cfg3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(2) && cfg1_q[7]) |=> $stable(cfg3_q));

   a_r6_int1_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_int1 |=> flag_q[1]);

   a_r7_fifo_push: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(6) && !cfg1_q[7])
      |=> (fifo_wr && fifo_wdata == $past(bus_wdata)));

   a_r8_fifo_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(6)) |=> fifo_clr);

   a_r9_channel_range: assert property (@(posedge clk) disable iff (!rst_n)
      dac_wr |-> (int'(dac_ch) < NUM_CH));

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_wr && dac_wr));

endmodule

bind ao_hostreg ao_hostreg_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .NUM_CH (NUM_CH),
   .CH_W   (CH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .cfg1_q     (cfg1_q),
   .cfg3_q     (cfg3_q),
   .flag_q     (flag_q),
   .ev_int1    (ev_int1),
   .fifo_wr    (fifo_wr),
   .fifo_wdata (fifo_wdata),
   .fifo_clr   (fifo_clr),
   .dac_wr     (dac_wr),
   .dac_ch     (dac_ch)
);

// File: tb/ao_hostreg_bench.sv
`timescale 1ns/1ps
module ao_hostreg_bench;

   localparam int NCH = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ev_tc = 1'b0, ev_int1 = 1'b0, ev_int2 = 1'b0;
   logic        fifo_half = 1'b0, fifo_empty = 1'b1, fifo_full = 1'b0, prom_dout = 1'b0;
   logic [15:0] cfg1_q, cfg2_q, cfg3_q, fifo_wdata;
   logic        fifo_wr, fifo_clr, dac_wr;
   logic [3:0]  dac_ch;
   logic [11:0] dac_data;

   always #2.5 clk = ~clk;

   ao_hostreg u_ao_hostreg (.*);

   int n_chk = 0, n_bad = 0;

   // reference state
   logic [15:0] m_c1 = 0, m_c2 = 0, m_c3 = 0, m_fd = 0;
   logic        m_tc = 0, m_i1 = 0, m_i2 = 0, m_fw = 0, m_fc = 0, m_dw = 0;
   logic [3:0]  m_ch = 0;
   logic [11:0] m_dd = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic check_regs(input string tag);
      chk({tag, " R2 cfg1"}, cfg1_q, m_c1);
      chk({tag, " R4 cfg2"}, cfg2_q, m_c2);
      chk({tag, " R4 cfg3"}, cfg3_q, m_c3);
      chk({tag, " R7 fifo_wr"}, fifo_wr, m_fw);
      chk({tag, " R7 fifo_wdata"}, fifo_wdata, m_fd);
      chk({tag, " R8 fifo_clr"}, fifo_clr, m_fc);
      chk({tag, " R9 dac_wr"}, dac_wr, m_dw);
      chk({tag, " R9 dac_ch"}, dac_ch, m_ch);
      chk({tag, " R9 dac_data"}, dac_data, m_dd);
   endtask

   // one bus cycle: drive at negedge, check read data, advance model, check registers
   task automatic cyc(input string tag, input logic w, input logic r, input int a,
                      input logic [15:0] d, input logic [2:0] ev);
      logic bank;
      logic [15:0] st;
      bus_wr = w; bus_rd = r; bus_addr = 4'(a); bus_wdata = d;
      {ev_int2, ev_int1, ev_tc} = ev;
      #1;
      st = {9'b0, fifo_half, fifo_empty, fifo_full, m_i2, m_i1, m_tc, prom_dout};
      chk({tag, " R3 R11 rdata"}, bus_rdata, (r && a == 5) ? st : 16'h0);
      @(posedge clk);
      bank = m_c1[7];
      m_tc = ev[0] | (m_tc & !(w && bank && a == 0));
      m_i1 = ev[1] | (m_i1 & !(w && bank && a == 1));
      m_i2 = ev[2] | (m_i2 & !(w && bank && a == 2));
      m_fw = 0; m_dw = 0; m_fc = r && a == 6;
      if (w) begin
         if (a == 5) m_c1 = d & 16'hF9FF;
         if (a == 1 && !bank) m_c2 = d;
         if (a == 2 && !bank) m_c3 = d & 16'h004F;
         if (a == 6 && !bank) begin m_fw = 1; m_fd = d; end
         else if (a >= 6 && a - 6 < NCH) begin
            m_dw = 1; m_ch = 4'(a - 6); m_dd = d[11:0];
         end
      end
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; {ev_int2, ev_int1, ev_tc} = 3'b000;
      check_regs(tag);
   endtask

   task automatic rd_status(input string tag);
      cyc(tag, 0, 1, 5, 16'h0, 3'b000);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_regs("R1 in reset");
      chk("R1 reset flags via status", bus_rdata, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_regs("R1 after reset");
      rd_status("R1 R3 status after reset");

      // R2 masking, bank bit follows
      cyc("R2 cfg1 all ones", 1, 0, 5, 16'hFFFF, 3'b000);
      cyc("R2 cfg1 mixed", 1, 0, 5, 16'h5A34, 3'b000);
      cyc("R2 cfg1 clear", 1, 0, 5, 16'h0000, 3'b000);
      // R4 bank 0 config
      cyc("R4 cfg2 write", 1, 0, 1, 16'hA5C3, 3'b000);
      cyc("R4 cfg3 all ones", 1, 0, 2, 16'hFFFF, 3'b000);
      cyc("R4 cfg3 mixed", 1, 0, 2, 16'h00B4, 3'b000);
      // R11 ignored writes and reads
      cyc("R11 bank0 word0", 1, 0, 0, 16'h1234, 3'b000);
      cyc("R11 word3", 1, 0, 3, 16'hFFFF, 3'b000);
      cyc("R11 word4", 1, 0, 4, 16'hFFFF, 3'b000);
      cyc("R11 read word1", 0, 1, 1, 16'h0, 3'b000);
      // R6 flags set and hold; R3 status fields
      fifo_half = 1; fifo_empty = 0; prom_dout = 1;
      cyc("R6 tc pulse", 0, 0, 0, 16'h0, 3'b001);
      cyc("R6 int1 pulse", 0, 0, 0, 16'h0, 3'b010);
      rd_status("R3 R6 status tc int1");
      cyc("R6 int2 pulse", 0, 0, 0, 16'h0, 3'b100);
      fifo_full = 1; fifo_half = 0;
      rd_status("R3 R6 status all flags");
      // R7 bank 0 queue push, R8 clear
      cyc("R7 push a", 1, 0, 6, 16'hBEEF, 3'b000);
      cyc("R7 push b", 1, 0, 6, 16'h0123, 3'b000);
      cyc("R8 queue clear", 0, 1, 6, 16'h0, 3'b000);
      // R9 channels 1..NCH-1 in bank 0
      for (int n = 1; n < NCH; n++)
         cyc("R9 channel bank0", 1, 0, 6 + n, 16'(16'hF000 + n * 16'h111), 3'b000);
      // bank 2 selected
      cyc("R2 select bank2", 1, 0, 5, 16'h0080, 3'b000);
      cyc("R5 clear int1", 1, 0, 1, 16'hFFFF, 3'b000);
      rd_status("R5 status after int1 clear");
      cyc("R5 clear tc", 1, 0, 0, 16'h0000, 3'b000);
      cyc("R6 set wins over clear", 1, 0, 2, 16'hFFFF, 3'b100);
      rd_status("R6 status int2 kept");
      cyc("R5 clear int2", 1, 0, 2, 16'h0, 3'b000);
      rd_status("R5 status all clear");
      cyc("R10 channel0 bank2", 1, 0, 6, 16'h0ABC, 3'b000);
      cyc("R9 channel5 bank2", 1, 0, 11, 16'h7321, 3'b000);
      cyc("R8 clear in bank2", 0, 1, 6, 16'h0, 3'b000);
      cyc("R2 deselect bank2", 1, 0, 5, 16'h0000, 3'b000);
      cyc("R7 push after bank0", 1, 0, 6, 16'h4444, 3'b000);
      cyc("idle", 0, 0, 0, 16'h0, 3'b000);
      finish_run();
   end

endmodule